// File: doc/BRIEF.md
# Subtract-Immediate-With-Borrow Execute Slice

This block is one execute slice of a small 8-bit processor. Each cycle it may take in a 16-bit instruction word with a valid strobe. If the word is the subtract-immediate-with-borrow instruction, the slice reads one register from a 32-entry by 8-bit register file. It subtracts an 8-bit constant and the incoming carry from that register and writes the 8-bit difference back to the same register. In the same cycle it recomputes six arithmetic flags in an 8-bit status register.

Only the upper half of the register file can be a target. The destination is packed in the word as a 4-bit offset from the base register. The 8-bit constant is split into two nibbles, one on each side of that offset. A side port lets a host preset any register or the status byte and read any register back. Fetch, the program counter, memory and every other opcode lie outside this slice.

Top module: `imm_sub_borrow_unit`

## Requirements
- R1: A word is accepted only when bits 15:12 equal 4'b0100. The constant K takes word bits 11:8 as its upper nibble and bits 3:0 as its lower nibble. The destination index is 16 plus word bits 7:4, so K spans 0..255 and the destination spans 16..31.
- R2: On the clock edge where an accepted word has its strobe high, the destination register is loaded with (Rd - K - C) mod 256. C is the carry flag before the edge. A second instruction on the next edge sees the updated register and flags.
- R3: With R the 8-bit result, define the borrow vector B = (~Rd & K) | (K & R) | (R & ~Rd). Half-carry becomes B[3] and carry becomes B[7].
- R4: Overflow becomes bit 7 of (Rd & ~K & ~R) | (~Rd & K & R).
- R5: Negative becomes R[7], and sign becomes negative XOR overflow.
- R6: Zero becomes 1 only if R is zero and zero was already 1 before the edge. In every other case it becomes 0.
- R7: The status byte bit positions are carry 0, zero 1, negative 2, overflow 3, sign 4, half-carry 5, bit 6 T and bit 7 I. An executed instruction leaves bits 7:6 unchanged.
- R8: An executed instruction writes no register-file entry other than its destination.
- R9: A word whose bits 15:12 differ from 4'b0100 changes nothing. A word with the strobe low also changes nothing.
- R10: A synchronous active-high reset clears the status byte and all 32 register entries to zero.
- R11: The debug register write and debug status write take effect on the next edge. When either one is high, an instruction in the same cycle is dropped entirely.
- R12: The debug read data is registered. After an edge it holds the entry addressed before that edge, with the value it had before any write on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_vld | input | 1 | Instruction word valid strobe |
| insn_word | input | 16 | Instruction word |
| dbg_reg_we | input | 1 | Debug register write enable |
| dbg_reg_waddr | input | 5 | Debug register write index |
| dbg_reg_wdata | input | 8 | Debug register write data |
| dbg_stat_we | input | 1 | Debug status byte write enable |
| dbg_stat_wdata | input | 8 | Debug status byte write data |
| dbg_reg_raddr | input | 5 | Debug register read index |
| dbg_reg_rdata | output | 8 | Registered debug register read data |
| stat_q | output | 8 | Status byte |

## Verification
The bench builds the slice with its default parameters: 8-bit data, 32 entries and a target base of 16. This puts both ends of the destination range (16 and 31) and the full 0..255 constant range within reach. Operand pairs are chosen to drive each flag to 0 and to 1. Each pair runs under all four starting combinations of carry and zero, so the borrow-in path and the zero-chaining rule are both exercised. Neighbouring registers, mismatched opcodes, a low strobe, collisions with debug writes and a mid-run reset are each checked through the read port and the status byte.

// File: rtl/isb_pkg.sv
package isb_pkg;

  // Status byte bit positions
  localparam int unsigned ST_C = 0;
  localparam int unsigned ST_Z = 1;
  localparam int unsigned ST_N = 2;
  localparam int unsigned ST_V = 3;
  localparam int unsigned ST_S = 4;
  localparam int unsigned ST_H = 5;
  localparam int unsigned ST_T = 6;
  localparam int unsigned ST_I = 7;
  localparam int unsigned ST_W = 8;

  // Flags produced by one subtract
  typedef struct packed {
    logic h;
    logic s;
    logic v;
    logic n;
    logic z;
    logic c;
  } isb_flags_t;

endpackage

// File: rtl/isb_decode.sv
module isb_decode #(
  parameter int unsigned INSN_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned TGT_BASE = 16,
  parameter logic [3:0]  OPC_VAL  = 4'b0100
) (
  input  logic              insn_vld,
  input  logic [INSN_W-1:0] insn_word,
  input  logic              block,
  output logic              exec_en,
  output logic [IDX_W-1:0]  dest_idx,
  output logic [DATA_W-1:0] imm
);

  localparam int unsigned NIB_W  = DATA_W / 2;
  localparam int unsigned OPC_LO = INSN_W - 4;
  localparam int unsigned KHI_LO = OPC_LO - NIB_W;
  localparam int unsigned DST_LO = NIB_W;

  logic [3:0]       opc;
  logic [NIB_W-1:0] k_hi;
  logic [NIB_W-1:0] k_lo;
  logic [NIB_W-1:0] d_off;

  always_comb begin
    opc      = insn_word[INSN_W-1:OPC_LO];
    k_hi     = insn_word[KHI_LO +: NIB_W];
    d_off    = insn_word[DST_LO +: NIB_W];
    k_lo     = insn_word[0 +: NIB_W];
    imm      = {k_hi, k_lo};
    dest_idx = IDX_W'(TGT_BASE) + IDX_W'(d_off);
    exec_en  = insn_vld && (opc == OPC_VAL) && !block;
  end

endmodule

// File: rtl/isb_alu.sv
module isb_alu
  import isb_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned HALF_BIT = 3
) (
  input  logic [DATA_W-1:0] opd,
  input  logic [DATA_W-1:0] imm,
  input  logic              c_in,
  input  logic              z_in,
  output logic [DATA_W-1:0] res,
  output isb_flags_t        flags
);

  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] brw;
  logic [DATA_W-1:0] ovf;

  always_comb begin
    res     = opd - imm - DATA_W'(c_in);
    brw     = (~opd & imm) | (imm & res) | (res & ~opd);
    ovf     = (opd & ~imm & ~res) | (~opd & imm & res);
    flags.c = brw[MSB];
    flags.h = brw[HALF_BIT];
    flags.v = ovf[MSB];
    flags.n = res[MSB];
    flags.s = res[MSB] ^ ovf[MSB];
    flags.z = z_in && (res == '0);
  end

endmodule

// File: rtl/isb_regfile.sv
module isb_regfile #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ex_raddr,
  output logic [DATA_W-1:0] ex_rdata,
  input  logic [IDX_W-1:0]  dbg_raddr,
  output logic [DATA_W-1:0] dbg_rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)
        mem[g] <= '0;
      else if (we && (waddr == IDX_W'(g)))
        mem[g] <= wdata;
    end

    p_entry_clear_r10: assert property (@(posedge clk)
      rst |=> (mem[g] == '0));
  end

  assign ex_rdata = mem[ex_raddr];

  always_ff @(posedge clk) begin
    if (rst)
      dbg_rdata <= '0;
    else
      dbg_rdata <= mem[dbg_raddr];
  end

  // R12: read data shows the entry as it was before the edge
  p_rd_old_r12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dbg_rdata == $past(mem[dbg_raddr])));

endmodule

// File: rtl/isb_status.sv
module isb_status
  import isb_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            dbg_we,
  input  logic [ST_W-1:0] dbg_wdata,
  input  logic            exec_en,
  input  isb_flags_t      flags,
  output logic [ST_W-1:0] stat_q
);

  logic [ST_W-1:0] stat_d;

  always_comb begin
    stat_d = stat_q;
    if (dbg_we) begin
      stat_d = dbg_wdata;
    end else if (exec_en) begin
      stat_d[ST_C] = flags.c;
      stat_d[ST_Z] = flags.z;
      stat_d[ST_N] = flags.n;
      stat_d[ST_V] = flags.v;
      stat_d[ST_S] = flags.s;
      stat_d[ST_H] = flags.h;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      stat_q <= '0;
    else
      stat_q <= stat_d;
  end

  p_reset_stat_r10: assert property (@(posedge clk)
    rst |=> (stat_q == '0));

  p_ti_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (exec_en && !dbg_we) |=> (stat_q[ST_I:ST_T] == $past(stat_q[ST_I:ST_T])));

  p_zero_chain_r6: assert property (@(posedge clk) disable iff (rst)
    (exec_en && !dbg_we && !stat_q[ST_Z]) |=> !stat_q[ST_Z]);

  p_sign_rel_r5: assert property (@(posedge clk) disable iff (rst)
    (exec_en && !dbg_we) |=> (stat_q[ST_S] == (stat_q[ST_N] ^ stat_q[ST_V])));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!exec_en && !dbg_we) |=> $stable(stat_q));

endmodule

// File: rtl/imm_sub_borrow_unit.sv
module imm_sub_borrow_unit
  import isb_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned DEPTH    = 32,
  parameter int unsigned TGT_BASE = 16,
  parameter int unsigned INSN_W   = 16,
  parameter int unsigned IDX_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              insn_vld,
  input  logic [INSN_W-1:0] insn_word,
  input  logic              dbg_reg_we,
  input  logic [IDX_W-1:0]  dbg_reg_waddr,
  input  logic [DATA_W-1:0] dbg_reg_wdata,
  input  logic              dbg_stat_we,
  input  logic [ST_W-1:0]   dbg_stat_wdata,
  input  logic [IDX_W-1:0]  dbg_reg_raddr,
  output logic [DATA_W-1:0] dbg_reg_rdata,
  output logic [ST_W-1:0]   stat_q
);

  logic              exec_en;
  logic              dbg_any;
  logic [IDX_W-1:0]  dest_idx;
  logic [DATA_W-1:0] imm;
  logic [DATA_W-1:0] opd;
  logic [DATA_W-1:0] res;
  isb_flags_t        flags;
  logic              rf_we;
  logic [IDX_W-1:0]  rf_waddr;
  logic [DATA_W-1:0] rf_wdata;

  assign dbg_any = dbg_reg_we | dbg_stat_we;

  isb_decode #(
    .INSN_W   (INSN_W),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W),
    .TGT_BASE (TGT_BASE)
  ) u_dec (
    .insn_vld  (insn_vld),
    .insn_word (insn_word),
    .block     (dbg_any),
    .exec_en   (exec_en),
    .dest_idx  (dest_idx),
    .imm       (imm)
  );

  isb_alu #(
    .DATA_W (DATA_W)
  ) u_alu (
    .opd   (opd),
    .imm   (imm),
    .c_in  (stat_q[ST_C]),
    .z_in  (stat_q[ST_Z]),
    .res   (res),
    .flags (flags)
  );

  always_comb begin
    rf_we    = dbg_reg_we | exec_en;
    rf_waddr = dbg_reg_we ? dbg_reg_waddr : dest_idx;
    rf_wdata = dbg_reg_we ? dbg_reg_wdata : res;
  end

  isb_regfile #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .IDX_W  (IDX_W)
  ) u_rf (
    .clk       (clk),
    .rst       (rst),
    .we        (rf_we),
    .waddr     (rf_waddr),
    .wdata     (rf_wdata),
    .ex_raddr  (dest_idx),
    .ex_rdata  (opd),
    .dbg_raddr (dbg_reg_raddr),
    .dbg_rdata (dbg_reg_rdata)
  );

  isb_status u_st (
    .clk       (clk),
    .rst       (rst),
    .dbg_we    (dbg_stat_we),
    .dbg_wdata (dbg_stat_wdata),
    .exec_en   (exec_en),
    .flags     (flags),
    .stat_q    (stat_q)
  );

  p_dest_upper_r8: assert property (@(posedge clk) disable iff (rst)
    exec_en |-> (dest_idx >= IDX_W'(TGT_BASE)));

  p_dbg_wins_r11: assert property (@(posedge clk) disable iff (rst)
    dbg_any |-> !exec_en);

  p_opcode_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (insn_word[INSN_W-1:INSN_W-4] != 4'b0100) |-> !exec_en);

endmodule

// File: tb/imm_sub_borrow_unit_tb_top.sv
`timescale 1ns/1ps
module imm_sub_borrow_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       insn_vld = 1'b0;
  logic [15:0] insn_word = '0;
  logic       dbg_reg_we = 1'b0;
  logic [4:0] dbg_reg_waddr = '0;
  logic [7:0] dbg_reg_wdata = '0;
  logic       dbg_stat_we = 1'b0;
  logic [7:0] dbg_stat_wdata = '0;
  logic [4:0] dbg_reg_raddr = '0;
  logic [7:0] dbg_reg_rdata;
  logic [7:0] stat_q;

  always #4 clk = ~clk;

  imm_sub_borrow_unit dut_i (
    .clk            (clk),
    .rst            (rst),
    .insn_vld       (insn_vld),
    .insn_word      (insn_word),
    .dbg_reg_we     (dbg_reg_we),
    .dbg_reg_waddr  (dbg_reg_waddr),
    .dbg_reg_wdata  (dbg_reg_wdata),
    .dbg_stat_we    (dbg_stat_we),
    .dbg_stat_wdata (dbg_stat_wdata),
    .dbg_reg_raddr  (dbg_reg_raddr),
    .dbg_reg_rdata  (dbg_reg_rdata),
    .stat_q         (stat_q)
  );

  typedef struct {
    int         due;
    bit         is_stat;
    logic [7:0] mask;
    logic [7:0] exp;
    string      tag;
  } sb_item_t;

  sb_item_t   sb_q[$];
  int         checks = 0;
  int         errors = 0;
  int         mcyc   = 0;
  logic [7:0] ref_rf [32];
  logic [7:0] ref_st;

  // Monitor: pops items due on this cycle
  always @(posedge clk) begin
    #2;
    mcyc++;
    while (sb_q.size() > 0 && sb_q[0].due == mcyc) begin
      sb_item_t it;
      logic [7:0] act;
      it  = sb_q.pop_front();
      act = it.is_stat ? stat_q : dbg_reg_rdata;
      checks++;
      if ((act & it.mask) !== (it.exp & it.mask)) begin
        errors++;
        $display("FAIL %s: actual=%02h expected=%02h mask=%02h",
                 it.tag, act, it.exp, it.mask);
      end
    end
  end

  function automatic logic [15:0] enc(int d, logic [7:0] k);
    logic [3:0] off;
    off = 4'(d - 16);
    return {4'b0100, k[7:4], off, k[3:0]};
  endfunction

  // Model from the requirement text
  function automatic void model_exec(int d, logic [7:0] k);
    logic [7:0] a, r, b, v;
    a = ref_rf[d];
    r = a - k - {7'd0, ref_st[0]};
    b = (~a & k) | (k & r) | (r & ~a);
    v = (a & ~k & ~r) | (~a & k & r);
    ref_st[0] = b[7];
    ref_st[5] = b[3];
    ref_st[3] = v[7];
    ref_st[2] = r[7];
    ref_st[4] = r[7] ^ v[7];
    ref_st[1] = ref_st[1] & (r == 8'h00);
    ref_rf[d] = r;
  endfunction

  task automatic quiet();
    insn_vld    = 1'b0;
    dbg_reg_we  = 1'b0;
    dbg_stat_we = 1'b0;
  endtask

  task automatic wr_reg(int a, logic [7:0] d);
    @(negedge clk);
    quiet();
    dbg_reg_we = 1'b1; dbg_reg_waddr = 5'(a); dbg_reg_wdata = d;
    ref_rf[a] = d;
  endtask

  task automatic wr_stat(logic [7:0] s);
    @(negedge clk);
    quiet();
    dbg_stat_we = 1'b1; dbg_stat_wdata = s;
    ref_st = s;
  endtask

  task automatic issue(logic [15:0] w, bit vld);
    @(negedge clk);
    quiet();
    insn_vld = vld; insn_word = w;
    if (vld && w[15:12] == 4'b0100)
      model_exec(16 + int'(w[7:4]), {w[11:8], w[3:0]});
  endtask

  task automatic chk_reg(int a, string tag);
    @(negedge clk);
    quiet();
    dbg_reg_raddr = 5'(a);
    sb_q.push_back('{mcyc + 1, 1'b0, 8'hFF, ref_rf[a], tag});
  endtask

  task automatic chk_lit(int a, logic [7:0] e, string tag);
    @(negedge clk);
    quiet();
    dbg_reg_raddr = 5'(a);
    sb_q.push_back('{mcyc + 1, 1'b0, 8'hFF, e, tag});
  endtask

  task automatic chk_stat(logic [7:0] m, string tag);
    @(negedge clk);
    quiet();
    sb_q.push_back('{mcyc + 1, 1'b1, m, ref_st, tag});
  endtask

  task automatic chk_stat_lit(logic [7:0] e, string tag);
    @(negedge clk);
    quiet();
    sb_q.push_back('{mcyc + 1, 1'b1, 8'hFF, e, tag});
  endtask

  task automatic flags_all();
    chk_stat(8'h21, "R3 half-carry/carry");
    chk_stat(8'h08, "R4 overflow");
    chk_stat(8'h14, "R5 negative/sign");
    chk_stat(8'h02, "R6 zero chain");
    chk_stat(8'hC0, "R7 T/I kept");
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] pv [7];
    logic [7:0] pk [7];
    pv = '{8'h00, 8'hff, 8'hfe, 8'h0f, 8'h0f, 8'h01, 8'h80};
    pk = '{8'h00, 8'h00, 8'h01, 8'h00, 8'hf0, 8'h02, 8'h01};
    for (int i = 0; i < 32; i++) ref_rf[i] = 8'h00;
    ref_st = 8'h00;

    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk_stat_lit(8'h00, "R10 status after reset");
    chk_lit(16, 8'h00, "R10 r16 after reset");
    chk_lit(3, 8'h00, "R10 r3 after reset");

    // Literal cases
    wr_reg(16, 8'h00); wr_stat(8'h01);
    issue(enc(16, 8'h00), 1'b1);
    chk_lit(16, 8'hFF, "R2 0-0-1 wraps");
    chk_stat_lit(8'h35, "R3 borrow flags 0-0-1");
    wr_reg(31, 8'h80); wr_stat(8'h00);
    issue(enc(31, 8'h01), 1'b1);
    chk_lit(31, 8'h7F, "R1 top dest r31");
    chk_stat_lit(8'h38, "R4 overflow 80-01");
    wr_reg(22, 8'h5A); wr_stat(8'h00);
    issue(enc(22, 8'hA5), 1'b1);
    chk_lit(22, 8'hB5, "R1 split immediate A5");

    // Sweep operands under every carry/zero start
    for (int cz = 0; cz < 4; cz++) begin
      for (int i = 0; i < 7; i++) begin
        int d;
        d = 16 + ((i * 5 + cz * 3) % 16);
        wr_reg(d, pv[i]);
        wr_stat({(cz[0] ? 2'b11 : 2'b01), 4'b0000, cz[1], cz[0]});
        issue(enc(d, pk[i]), 1'b1);
        chk_reg(d, "R2 result");
        flags_all();
      end
    end

    // Neighbour isolation
    wr_reg(19, 8'h11); wr_reg(21, 8'h22); wr_reg(5, 8'h33); wr_reg(20, 8'h40);
    issue(enc(20, 8'h10), 1'b1);
    chk_reg(20, "R8 dest r20");
    chk_reg(19, "R8 r19 untouched");
    chk_reg(21, "R8 r21 untouched");
    chk_reg(5, "R8 r5 untouched");

    // Back-to-back: second sees first's carry and value
    wr_reg(17, 8'h00); wr_stat(8'h02);
    issue(enc(17, 8'h01), 1'b1);
    issue(enc(17, 8'h00), 1'b1);
    chk_lit(17, 8'hFE, "R2 back-to-back uses new carry");
    chk_stat(8'hFF, "R2 back-to-back status");

    // Ignored words
    wr_reg(18, 8'h77); wr_stat(8'h03);
    issue(16'h5812, 1'b1);
    chk_lit(18, 8'h77, "R9 wrong opcode reg");
    chk_stat_lit(8'h03, "R9 wrong opcode status");
    issue(enc(18, 8'h01), 1'b0);
    chk_lit(18, 8'h77, "R9 strobe low reg");
    chk_stat_lit(8'h03, "R9 strobe low status");

    // Debug write collides with instruction
    @(negedge clk);
    quiet();
    insn_vld = 1'b1; insn_word = enc(18, 8'h01);
    dbg_stat_we = 1'b1; dbg_stat_wdata = 8'h40;
    ref_st = 8'h40;
    chk_lit(18, 8'h77, "R11 insn dropped on status write");
    chk_stat_lit(8'h40, "R11 debug status wins");
    @(negedge clk);
    quiet();
    insn_vld = 1'b1; insn_word = enc(18, 8'h01);
    dbg_reg_we = 1'b1; dbg_reg_waddr = 5'd25; dbg_reg_wdata = 8'h9C;
    ref_rf[25] = 8'h9C;
    chk_lit(18, 8'h77, "R11 insn dropped on reg write");
    chk_lit(25, 8'h9C, "R11 debug reg write");
    chk_stat_lit(8'h40, "R11 status unchanged");

    // Read returns pre-write value on same edge
    @(negedge clk);
    quiet();
    dbg_reg_we = 1'b1; dbg_reg_waddr = 5'd25; dbg_reg_wdata = 8'h01;
    dbg_reg_raddr = 5'd25;
    sb_q.push_back('{mcyc + 1, 1'b0, 8'hFF, 8'h9C, "R12 read shows old value"});
    ref_rf[25] = 8'h01;
    chk_reg(25, "R12 read after write");

    // Mid-run reset
    @(negedge clk);
    quiet();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 32; i++) ref_rf[i] = 8'h00;
    ref_st = 8'h00;
    chk_lit(25, 8'h00, "R10 r25 cleared");
    chk_lit(20, 8'h00, "R10 r20 cleared");
    chk_stat_lit(8'h00, "R10 status cleared");

    repeat (3) @(posedge clk);
    #3;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", sb_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule